// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Generator

This block drives a single output pulse of programmable length each time a chosen edge appears on an external trigger input. A 16-bit reload value is held in a latch. When a valid edge is seen, that value is copied into a down-counter and the output moves to its active level. The counter then decrements on every prescaled tick while counting is enabled. When it steps past zero, the output goes back to its idle level and a one-cycle end-of-pulse interrupt is raised.

Software picks three things: which edge of the trigger counts, whether the pulse is high-going or low-going, and the pulse length. The trigger input is treated as asynchronous and goes through a synchroniser before edge detection. Every detected edge also sets a sticky request flag, which stays set until it is cleared.

The controller is a three-state machine:
- `ST_OFF`: the mode is not selected.
- `ST_ARMED`: the output is idle and the block waits for an edge.
- `ST_ACTIVE`: the output is active and the counter is running or held.

It has five transitions:
- "enter" (`ST_OFF`→`ST_ARMED`) when the mode is selected.
- "fire" (`ST_ARMED`→`ST_ACTIVE`) on a valid edge.
- "expire" (`ST_ACTIVE`→`ST_ARMED`) on underflow.
- "leave" (`ST_ARMED` or `ST_ACTIVE`→`ST_OFF`) when the mode is deselected.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: The block is enabled only when `op_mode` equals 3'b101 and `evt_mode` is 0. Otherwise `pulse_out` rests at the idle level and trigger edges produce no pulse.
- R2: With `edge_sel`=1 a rising trigger edge starts a pulse. With `edge_sel`=0 a falling edge starts it. The opposite edge starts nothing.
- R3: Each detected trigger edge sets `trig_irq`. The flag stays at 1 until a `trig_irq_clr` strobe clears it.
- R4: The idle level of `pulse_out` equals `pulse_pol`. The active level is its inverse.
- R5: A reload value N gives an active phase of exactly N+1 tick periods. The counter is loaded from the reload latch when the pulse starts.
- R6: Writing the reload latch during a pulse does not change that pulse. The new value sets the length of the next pulse.
- R7: While `cnt_en` or `tick` is low the counter holds. A trigger that arrives while counting is stopped still makes the output active, and the output stays active until counting resumes and an underflow occurs.
- R8: On underflow `pulse_out` returns to idle, and `uf_irq` is high for exactly one clock cycle, in the first idle cycle.
- R9: A trigger edge during an active pulse does not restart or stretch the pulse. It still sets `trig_irq`.
- R10: Changing `edge_sel` while the trigger input is steady can itself count as a valid edge and start a pulse one clock later.
- R11: The trigger passes through a two-flop synchroniser. The output turns active on the third rising clock edge after the trigger input changes, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Operating-mode field; 3'b101 selects this block |
| evt_mode | input | 1 | Event-counter switch; must be 0 for this block |
| pulse_pol | input | 1 | Idle level of the output (0: high pulse, 1: low pulse) |
| edge_sel | input | 1 | Trigger edge: 1 rising, 0 falling |
| trig_in | input | 1 | Asynchronous trigger input |
| cnt_en | input | 1 | Counting enable |
| tick | input | 1 | Prescaled count tick, one clock wide |
| width_wr | input | 1 | Write strobe for the reload latch |
| width_data | input | 16 | Reload value (pulse length minus one, in ticks) |
| trig_irq_clr | input | 1 | Clears the trigger request flag |
| pulse_out | output | 1 | Pulse output |
| trig_irq | output | 1 | Sticky trigger request flag |
| uf_irq | output | 1 | One-cycle end-of-pulse (underflow) request |

## Verification
The hardest case to reach from the ports is a trigger edge that arrives while the pulse is already active. The stimulus walks the trigger input back to idle and then to active again in the middle of a measured pulse, and checks that the total length is unchanged. It also clears the flag in between, so the second edge shows up only through `trig_irq`. A trigger during a stopped count is reached by holding `tick` low, then releasing `cnt_en` and `tick` separately. The edge caused by switching `edge_sel` is reached by flipping the select while the trigger input is held steady.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } os_state_t;

    localparam logic [2:0] MODE_ONESHOT = 3'b101;

endpackage

// File: rtl/os_trig_sync.sv
module os_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic edge_sel,
    output logic edge_det
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_sel;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
        end
    end

    // the selected edge always looks like a rising edge of lvl_sel
    assign lvl_sel = edge_sel ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= lvl_sel;
        end
    end

    assign edge_det = lvl_sel & ~prev_q;

    // R2: a detection is followed by a cycle without one
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det && $stable(edge_sel) |=> !edge_det);

endmodule

// File: rtl/os_counter.sv
module os_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             load,
    input  logic             dec,
    output logic             zero
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr) begin
            latch_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= latch_q;
        end else if (dec) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);

    // R5: a start copies the latch value seen before that edge
    assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(latch_q));

    // R7: without load or decrement the count holds
    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !dec |=> $stable(count_q));

endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
    import oneshot_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_mode,
    input  logic             evt_mode,
    input  logic             pulse_pol,
    input  logic             edge_sel,
    input  logic             trig_in,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic             width_wr,
    input  logic [WIDTH-1:0] width_data,
    input  logic             trig_irq_clr,
    output logic             pulse_out,
    output logic             trig_irq,
    output logic             uf_irq
);

    os_state_t state_q;
    os_state_t state_d;
    logic      mode_on;
    logic      edge_det;
    logic      cnt_zero;
    logic      load;
    logic      dec;
    logic      underflow;

    assign mode_on = (op_mode == MODE_ONESHOT) && !evt_mode;

    os_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .edge_sel (edge_sel),
        .edge_det (edge_det)
    );

    assign load      = (state_q == ST_ARMED) && mode_on && edge_det;
    assign underflow = (state_q == ST_ACTIVE) && mode_on && cnt_en && tick && cnt_zero;
    assign dec       = (state_q == ST_ACTIVE) && mode_on && cnt_en && tick && !cnt_zero;

    os_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (width_wr),
        .wr_data (width_data),
        .load    (load),
        .dec     (dec),
        .zero    (cnt_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_on) state_d = ST_ARMED;            // enter
            end
            ST_ARMED: begin
                if (!mode_on)      state_d = ST_OFF;         // leave
                else if (edge_det) state_d = ST_ACTIVE;      // fire
            end
            ST_ACTIVE: begin
                if (!mode_on)       state_d = ST_OFF;        // leave
                else if (underflow) state_d = ST_ARMED;      // expire
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            trig_irq  <= 1'b0;
            uf_irq    <= 1'b0;
        end else begin
            pulse_out <= pulse_pol ^ (state_d == ST_ACTIVE);
            uf_irq    <= underflow;
            if (edge_det) begin
                trig_irq <= 1'b1;
            end else if (trig_irq_clr) begin
                trig_irq <= 1'b0;
            end
        end
    end

    // R3: every detected edge raises the request flag
    assert_edge_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> trig_irq);

    // R8: end-of-pulse request lasts one cycle
    assert_uf_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uf_irq |=> !uf_irq);

    // R8: when the request is seen the output is back at idle
    assert_idle_at_uf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uf_irq && $stable(pulse_pol) |-> pulse_out == pulse_pol);

    // R1: a deselected block keeps the output idle
    assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_OFF) && state_q == ST_OFF && $stable(pulse_pol)
        |-> pulse_out == pulse_pol);

endmodule

// File: tb/test_oneshot_pulse_gen.sv
module test_oneshot_pulse_gen;

    typedef struct packed {
        logic        pol;
        logic        esel;
        logic [15:0] width;
        logic [15:0] exp_len;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{pol: 1'b0, esel: 1'b1, width: 16'd0,   exp_len: 16'd1},
        '{pol: 1'b1, esel: 1'b0, width: 16'd1,   exp_len: 16'd2},
        '{pol: 1'b0, esel: 1'b0, width: 16'd4,   exp_len: 16'd5},
        '{pol: 1'b1, esel: 1'b1, width: 16'd9,   exp_len: 16'd10},
        '{pol: 1'b0, esel: 1'b1, width: 16'd200, exp_len: 16'd201}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_mode = 3'b000;
    logic        evt_mode = 1'b0;
    logic        pulse_pol = 1'b0;
    logic        edge_sel = 1'b0;
    logic        trig_in = 1'b1;
    logic        cnt_en = 1'b1;
    logic        tick = 1'b1;
    logic        width_wr = 1'b0;
    logic [15:0] width_data = '0;
    logic        trig_irq_clr = 1'b0;
    logic        pulse_out;
    logic        trig_irq;
    logic        uf_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    oneshot_pulse_gen i_oneshot_pulse_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_mode      (op_mode),
        .evt_mode     (evt_mode),
        .pulse_pol    (pulse_pol),
        .edge_sel     (edge_sel),
        .trig_in      (trig_in),
        .cnt_en       (cnt_en),
        .tick         (tick),
        .width_wr     (width_wr),
        .width_data   (width_data),
        .trig_irq_clr (trig_irq_clr),
        .pulse_out    (pulse_out),
        .trig_irq     (trig_irq),
        .uf_irq       (uf_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (pulse_out == ~pulse_pol && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic write_width(input logic [15:0] w);
        width_wr = 1'b1;
        width_data = w;
        @(negedge clk);
        width_wr = 1'b0;
    endtask

    task automatic clear_flag();
        trig_irq_clr = 1'b1;
        @(negedge clk);
        trig_irq_clr = 1'b0;
    endtask

    task automatic setup(input logic pol, input logic esel);
        op_mode = 3'b000;
        pulse_pol = pol;
        edge_sel = esel;
        trig_in = ~esel;
        wait_n(5);
        clear_flag();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        report();
    end

    initial begin
        int len;
        vec_t v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk(pulse_out == 1'b0, "R4 reset output", pulse_out, 0);
        chk(trig_irq == 1'b0, "R3 reset flag", trig_irq, 0);
        chk(uf_irq == 1'b0, "R8 reset uf", uf_irq, 0);

        // table walk: R2 R3 R4 R5 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            setup(v.pol, v.esel);
            write_width(v.width);
            op_mode = 3'b101;
            wait_n(2);
            chk(pulse_out == v.pol, "R4 idle level", pulse_out, v.pol);
            trig_in = v.esel;
            wait_n(2);
            chk(pulse_out == v.pol, "R11 not before third edge", pulse_out, v.pol);
            wait_n(1);
            chk(pulse_out == ~v.pol, "R2 selected edge fires", pulse_out, ~v.pol);
            chk(trig_irq == 1'b1, "R3 flag set", trig_irq, 1);
            measure(len);
            chk(len == int'(v.exp_len), "R5 pulse length", len, v.exp_len);
            chk(uf_irq == 1'b1, "R8 uf raised", uf_irq, 1);
            wait_n(1);
            chk(uf_irq == 1'b0, "R8 uf one cycle", uf_irq, 0);
            trig_in = ~v.esel;
            wait_n(5);
            chk(pulse_out == v.pol, "R2 opposite edge ignored", pulse_out, v.pol);
        end

        // R1: wrong mode encodings
        setup(1'b1, 1'b1);
        write_width(16'd3);
        op_mode = 3'b101;
        evt_mode = 1'b1;
        wait_n(2);
        trig_in = 1'b1;
        wait_n(6);
        chk(pulse_out == 1'b1, "R1 event switch blocks", pulse_out, 1);
        evt_mode = 1'b0;
        setup(1'b0, 1'b1);
        op_mode = 3'b100;
        wait_n(2);
        trig_in = 1'b1;
        wait_n(6);
        chk(pulse_out == 1'b0, "R1 other mode blocks", pulse_out, 0);
        chk(trig_irq == 1'b1, "R3 flag set with mode off", trig_irq, 1);
        clear_flag();
        chk(trig_irq == 1'b0, "R3 flag cleared", trig_irq, 0);

        // R6: reload write during a pulse
        setup(1'b0, 1'b1);
        write_width(16'd8);
        op_mode = 3'b101;
        wait_n(2);
        trig_in = 1'b1;
        wait_n(3);
        width_wr = 1'b1;
        width_data = 16'd3;
        @(negedge clk);
        width_wr = 1'b0;
        measure(len);
        chk(len + 1 == 9, "R6 running pulse unchanged", len + 1, 9);
        trig_in = 1'b0;
        wait_n(4);
        trig_in = 1'b1;
        wait_n(3);
        measure(len);
        chk(len == 4, "R6 next pulse uses new value", len, 4);

        // R9: retrigger during a pulse
        trig_in = 1'b0;
        write_width(16'd10);
        wait_n(4);
        clear_flag();
        trig_in = 1'b1;
        wait_n(3);
        len = 0;
        while (pulse_out == 1'b1 && len < 1000) begin
            len++;
            if (len == 1) trig_irq_clr = 1'b1;
            if (len == 2) begin
                trig_irq_clr = 1'b0;
                trig_in = 1'b0;
            end
            if (len == 3) chk(trig_irq == 1'b0, "R3 cleared mid pulse", trig_irq, 0);
            if (len == 4) trig_in = 1'b1;
            @(negedge clk);
        end
        trig_irq_clr = 1'b0;
        chk(len == 11, "R9 no restart", len, 11);
        chk(trig_irq == 1'b1, "R9 flag from ignored edge", trig_irq, 1);

        // R7: trigger while counting stopped
        setup(1'b0, 1'b1);
        write_width(16'd5);
        op_mode = 3'b101;
        tick = 1'b0;
        wait_n(2);
        trig_in = 1'b1;
        wait_n(3);
        chk(pulse_out == 1'b1, "R7 active while stopped", pulse_out, 1);
        wait_n(40);
        chk(pulse_out == 1'b1, "R7 held without ticks", pulse_out, 1);
        chk(uf_irq == 1'b0, "R7 no underflow", uf_irq, 0);
        cnt_en = 1'b0;
        tick = 1'b1;
        wait_n(10);
        chk(pulse_out == 1'b1, "R7 held while disabled", pulse_out, 1);
        cnt_en = 1'b1;
        measure(len);
        chk(len == 6, "R7 resumes full length", len, 6);

        // R10: edge select flip on a steady input
        setup(1'b1, 1'b1);
        write_width(16'd2);
        op_mode = 3'b101;
        trig_in = 1'b0;
        wait_n(4);
        chk(pulse_out == 1'b1, "R10 idle before flip", pulse_out, 1);
        edge_sel = 1'b0;
        wait_n(1);
        chk(pulse_out == 1'b0, "R10 flip fires pulse", pulse_out, 0);
        measure(len);
        chk(len == 3, "R10 pulse length", len, 3);

        report();
    end

endmodule